// File: doc/BRIEF.md
# Serial Receive Buffer with Two-Word FIFO

This block turns a single serial data line into 32-bit words for a host bus. An external sequencer, modelled here as plain inputs, supplies a shift strobe for each incoming bit and an end-of-receive strobe when a unit of data is complete. Bits are collected in a receive shift register. The bit order is either MSB-first or LSB-first, chosen from a per-slave configuration bit.

There are two capture modes. In word mode a programmable width from 1 to 32 bits defines each word, and the bits above that width read as zero. In byte mode each end-of-receive strobe closes one 8-bit byte, and four bytes are packed into one word. Finished words enter a two-entry FIFO that the host drains with a read strobe. Two status outputs report the state of the block. The data-ready flag is high while the FIFO holds data. The read-error flag records data lost to an overrun and stays set until the host reads the status.

Top module: `serial_rx_buffer`

## Requirements
- R1: `sdi` is sampled into the shift register only on clock edges where `shift_en` is 1. Changes on `sdi` in other cycles have no effect on the captured data.
- R2: The bit order comes from `lsb_first_cfg[slave_sel]` for `slave_sel` values 0 to 5: 1 means LSB-first and 0 means MSB-first. Values 6 and 7 of `slave_sel` always use MSB-first. MSB-first puts the first received bit in the top bit of the unit (bit width-1, or bit 7 of a byte). LSB-first puts it in bit 0.
- R3: In word mode (`byte_mode`=0) the width is `word_width_m1`+1 bits. Each `rx_end` stores the last width bits (MSB-first) or the first width bits (LSB-first) in bits width-1:0 of a FIFO word. All bits above that width are 0.
- R4: In byte mode (`byte_mode`=1) each `rx_end` closes one 8-bit byte. The first byte of a word goes to bits 7:0, the second to bits 15:8, the third to 23:16 and the fourth to 31:24. The word is written to the FIFO only when the fourth byte closes.
- R5: The clock edge that writes a word into the FIFO also sets `rd_ready`, so it reads 1 in the following cycle.
- R6: The FIFO holds two words and keeps their order. A second word is stored while the first one is still unread.
- R7: A `rd_req` pulse pops the head word, which appears on `rd_data` after that clock edge. `rd_data` keeps its value until the next `rd_req`. A `rd_req` on an empty FIFO sets `rd_data` to 0 and leaves the FIFO unchanged.
- R8: `rd_ready` returns to 0 after the clock edge that removes the last stored word.
- R9: A word or byte that completes while the FIFO holds two words, with no `rd_req` in the same cycle, is discarded and sets `rd_err`. The stored words are not changed. If `rd_req` is high in that same cycle, the pop frees an entry and the new word is accepted.
- R10: `rd_err` stays 1 until a `stat_rd` pulse, which clears it after that edge. If a new overrun happens in the same cycle as `stat_rd`, the overrun wins and `rd_err` stays 1.
- R11: After reset, `rd_ready`, `rd_err` and `rd_data` are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdi | input | 1 | Serial receive data |
| shift_en | input | 1 | Shift strobe; samples `sdi` this cycle |
| rx_end | input | 1 | End-of-receive strobe; closes a word or byte |
| byte_mode | input | 1 | 1 = pack four bytes per word, 0 = variable-width word |
| word_width_m1 | input | 5 | Word-mode width minus one |
| slave_sel | input | 3 | Selects which per-slave order bit applies |
| lsb_first_cfg | input | 6 | Per-slave order bit, 1 = LSB-first |
| rd_req | input | 1 | Host read strobe; pops the FIFO head |
| rd_data | output | 32 | Last popped word (0 after an empty read) |
| stat_rd | input | 1 | Host status read; clears `rd_err` |
| rd_ready | output | 1 | FIFO holds at least one word |
| rd_err | output | 1 | A completed unit was lost to a full FIFO |

## Verification
The bench sends a 24-bit stream into a 20-bit word in both bit orders. A design that masks the wrong end of the shift register, or leaks upper bits, returns a different value. It also sends a stream in MSB-first order while the selected slave is set to LSB-first. It selects an out-of-range slave whose configuration bits are all ones. If the format bits are mis-indexed, these words come back bit-reversed. The FIFO is overfilled, both with and without a simultaneous pop and a simultaneous status read. A design that overwrote an entry would return the third word in place of the first. A wrong priority between the status clear and a new overrun shows up as a wrong `rd_err`. Byte packing is checked before and after the fourth byte, which catches early pushes and lane swaps. Strobe-free cycles toggle `sdi`, so a shifter that ignores its enable returns corrupted data.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;

    localparam int unsigned SRB_DATA_W     = 32;
    localparam int unsigned SRB_BYTE_W     = 8;
    localparam int unsigned SRB_FIFO_DEPTH = 2;
    localparam int unsigned SRB_NUM_SLAVES = 6;

endpackage

// File: rtl/srb_shifter.sv
module srb_shifter
    import srb_pkg::*;
#(
    parameter int unsigned DATA_W = SRB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    input  bit_order_e        order,
    input  logic              clear,
    output logic [DATA_W-1:0] bits_now
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t shf_q, shf_d, shf_upd;

    // shf_upd includes a bit shifted in this cycle, so a strobe that
    // closes a unit in the same cycle as the last shift still sees it.
    always_comb begin
        shf_upd = shf_q;
        if (shift_en) begin
            if (order == ORDER_MSB) begin
                shf_upd.shreg = {shf_q.shreg[DATA_W-2:0], sdi};
            end else if (shf_q.cnt < CNT_W'(DATA_W)) begin
                shf_upd.shreg[shf_q.cnt[IDX_W-1:0]] = sdi;
            end
            if (shf_q.cnt < CNT_W'(DATA_W)) begin
                shf_upd.cnt = shf_q.cnt + CNT_W'(1);
            end
        end
        shf_d = clear ? '0 : shf_upd;
    end

    assign bits_now = shf_upd.shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

endmodule

// File: rtl/srb_packer.sv
module srb_packer
    import srb_pkg::*;
#(
    parameter int unsigned DATA_W = SRB_DATA_W,
    parameter int unsigned BYTE_W = SRB_BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_mode,
    input  logic [$clog2(DATA_W)-1:0]  width_m1,
    input  logic                       rx_end,
    input  logic [DATA_W-1:0]          bits_now,
    input  logic                       room,
    output logic                       push,
    output logic [DATA_W-1:0]          push_data,
    output logic                       ovf
);
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] pack;
        logic [LANE_W-1:0] lane;
    } pk_t;

    pk_t               pk_q, pk_d;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] merged;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            wmask[i] = (i <= int'(width_m1));
        end
    end

    always_comb begin
        pk_d      = pk_q;
        push      = 1'b0;
        push_data = '0;
        ovf       = 1'b0;
        merged    = pk_q.pack;
        merged[int'(pk_q.lane)*BYTE_W +: BYTE_W] = bits_now[BYTE_W-1:0];

        if (!byte_mode) begin
            pk_d = '0;
        end

        if (rx_end) begin
            if (!room) begin
                ovf = 1'b1;
            end else if (!byte_mode) begin
                push      = 1'b1;
                push_data = bits_now & wmask;
            end else if (pk_q.lane == LANE_W'(LANES - 1)) begin
                push      = 1'b1;
                push_data = merged;
                pk_d      = '0;
            end else begin
                pk_d.pack = merged;
                pk_d.lane = pk_q.lane + LANE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

endmodule

// File: rtl/srb_fifo.sv
module srb_fifo
    import srb_pkg::*;
#(
    parameter int unsigned DATA_W = SRB_DATA_W,
    parameter int unsigned DEPTH  = SRB_FIFO_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic                         room,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_next,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             count;
        logic [DATA_W-1:0]            rd_data;
    } ff_t;

    ff_t  ff_q, ff_d;
    logic do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_pop = pop && (ff_q.count != '0);
    assign room   = (ff_q.count < CNT_W'(DEPTH)) || do_pop;

    always_comb begin
        ff_d = ff_q;
        if (pop) begin
            ff_d.rd_data = do_pop ? ff_q.mem[ff_q.rptr] : '0;
        end
        if (do_pop) begin
            ff_d.rptr = ptr_inc(ff_q.rptr);
        end
        if (push) begin
            ff_d.mem[ff_q.wptr] = push_data;
            ff_d.wptr           = ptr_inc(ff_q.wptr);
        end
        if (push && !do_pop) begin
            ff_d.count = ff_q.count + CNT_W'(1);
        end else if (!push && do_pop) begin
            ff_d.count = ff_q.count - CNT_W'(1);
        end
    end

    assign count      = ff_q.count;
    assign count_next = ff_d.count;
    assign rd_data    = ff_q.rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import srb_pkg::*;
#(
    parameter int unsigned DATA_W     = SRB_DATA_W,
    parameter int unsigned BYTE_W     = SRB_BYTE_W,
    parameter int unsigned FIFO_DEPTH = SRB_FIFO_DEPTH,
    parameter int unsigned NUM_SLAVES = SRB_NUM_SLAVES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sdi,
    input  logic                          shift_en,
    input  logic                          rx_end,
    input  logic                          byte_mode,
    input  logic [$clog2(DATA_W)-1:0]     word_width_m1,
    input  logic [$clog2(NUM_SLAVES)-1:0] slave_sel,
    input  logic [NUM_SLAVES-1:0]         lsb_first_cfg,
    input  logic                          rd_req,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          stat_rd,
    output logic                          rd_ready,
    output logic                          rd_err
);
    localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic rd_ready;
        logic rd_err;
    } st_t;

    st_t               st_q, st_d;
    bit_order_e        order;
    logic [DATA_W-1:0] bits_now;
    logic              room;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              ovf;
    logic [FCNT_W-1:0] fifo_count;
    logic [FCNT_W-1:0] fifo_count_next;

    always_comb begin
        order = ORDER_MSB;
        if (int'(slave_sel) < int'(NUM_SLAVES)) begin
            order = bit_order_e'(lsb_first_cfg[slave_sel]);
        end
    end

    srb_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdi      (sdi),
        .order    (order),
        .clear    (rx_end),
        .bits_now (bits_now)
    );

    srb_packer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .width_m1  (word_width_m1),
        .rx_end    (rx_end),
        .bits_now  (bits_now),
        .room      (room),
        .push      (push),
        .push_data (push_data),
        .ovf       (ovf)
    );

    srb_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (push_data),
        .pop        (rd_req),
        .room       (room),
        .count      (fifo_count),
        .count_next (fifo_count_next),
        .rd_data    (rd_data)
    );

    // A new overrun takes priority over a status-read clear.
    always_comb begin
        st_d          = st_q;
        st_d.rd_ready = (fifo_count_next != '0);
        if (ovf)          st_d.rd_err = 1'b1;
        else if (stat_rd) st_d.rd_err = 1'b0;
    end

    assign rd_ready = st_q.rd_ready;
    assign rd_err   = st_q.rd_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned FIFO_DEPTH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rd_req,
    input logic                         stat_rd,
    input logic                         byte_mode,
    input logic [$clog2(DATA_W)-1:0]    word_width_m1,
    input logic                         rd_ready,
    input logic                         rd_err,
    input logic [DATA_W-1:0]            rd_data,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
    input logic                         push,
    input logic [DATA_W-1:0]            push_data,
    input logic                         ovf
);
    localparam int unsigned WID_W = $clog2(DATA_W);

    logic [WID_W:0] wbits;
    assign wbits = {1'b0, word_width_m1} + (WID_W+1)'(1);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !byte_mode) |-> ((push_data >> wbits) == '0));

    assert_ready_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready == (fifo_count != '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= int'(FIFO_DEPTH));

    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fifo_count == '0) |=> (rd_data == '0));

    assert_ovf_keeps_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (int'(fifo_count) == int'(FIFO_DEPTH)));

    assert_ovf_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> rd_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && !stat_rd) |=> rd_err);

    assert_stat_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovf) |=> !rd_err);

endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (rd_req),
    .stat_rd       (stat_rd),
    .byte_mode     (byte_mode),
    .word_width_m1 (word_width_m1),
    .rd_ready      (rd_ready),
    .rd_err        (rd_err),
    .rd_data       (rd_data),
    .fifo_count    (fifo_count),
    .push          (push),
    .push_data     (push_data),
    .ovf           (ovf)
);

// File: tb/serial_rx_buffer_bench.sv
`timescale 1ns/1ps
module serial_rx_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        shift_en = 1'b0;
    logic        rx_end = 1'b0;
    logic        byte_mode = 1'b0;
    logic [4:0]  word_width_m1 = 5'd31;
    logic [2:0]  slave_sel = 3'd0;
    logic [5:0]  lsb_first_cfg = 6'b001110;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        stat_rd = 1'b0;
    logic        rd_ready;
    logic        rd_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    serial_rx_buffer u_serial_rx_buffer (
        .clk           (clk),
        .rst_n         (rst_n),
        .sdi           (sdi),
        .shift_en      (shift_en),
        .rx_end        (rx_end),
        .byte_mode     (byte_mode),
        .word_width_m1 (word_width_m1),
        .slave_sel     (slave_sel),
        .lsb_first_cfg (lsb_first_cfg),
        .rd_req        (rd_req),
        .rd_data       (rd_data),
        .stat_rd       (stat_rd),
        .rd_ready      (rd_ready),
        .rd_err        (rd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sends n bits of v; lsb selects transmit order. gap inserts a
    // strobe-free cycle with inverted sdi after every bit.
    task automatic send_bits(input logic [31:0] v, input int n, input bit lsb, input bit gap);
        for (int i = 0; i < n; i++) begin
            sdi      = lsb ? v[i] : v[n-1-i];
            shift_en = 1'b1;
            @(negedge clk);
            if (gap) begin
                shift_en = 1'b0;
                sdi      = ~sdi;
                @(negedge clk);
            end
        end
        shift_en = 1'b0;
    endtask

    task automatic end_unit(input bit with_pop, input bit with_stat);
        rx_end  = 1'b1;
        rd_req  = with_pop;
        stat_rd = with_stat;
        @(negedge clk);
        rx_end  = 1'b0;
        rd_req  = 1'b0;
        stat_rd = 1'b0;
    endtask

    task automatic pop(output logic [31:0] d);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        d = rd_data;
    endtask

    task automatic status_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] v);
        send_bits(v, 32, 1'b0, 1'b0);
        end_unit(1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R11 rd_ready", {31'd0, rd_ready}, 32'd0);
        chk("R11 rd_err",   {31'd0, rd_err},   32'd0);
        chk("R11 rd_data",  rd_data,           32'd0);
    endtask

    task automatic t_word_full();
        logic [31:0] d;
        byte_mode = 0; word_width_m1 = 5'd31; slave_sel = 3'd0;
        send_bits(32'hDEADBEEF, 32, 1'b0, 1'b0);
        chk("R5 not ready before end", {31'd0, rd_ready}, 32'd0);
        end_unit(1'b0, 1'b0);
        chk("R5 ready after push", {31'd0, rd_ready}, 32'd1);
        pop(d);
        chk("R2 msb 32-bit word", d, 32'hDEADBEEF);
        chk("R8 ready clears", {31'd0, rd_ready}, 32'd0);
        @(negedge clk);
        chk("R7 rd_data holds", rd_data, 32'hDEADBEEF);
    endtask

    task automatic t_width20();
        logic [31:0] d;
        byte_mode = 0; word_width_m1 = 5'd19;
        slave_sel = 3'd0;
        send_bits(32'h00FABCDE, 24, 1'b0, 1'b0);
        end_unit(1'b0, 1'b0);
        pop(d);
        chk("R3 20-bit msb masked", d, 32'h000ABCDE);
        slave_sel = 3'd2;
        send_bits(32'h00FABCDE, 24, 1'b1, 1'b0);
        end_unit(1'b0, 1'b0);
        pop(d);
        chk("R3 20-bit lsb masked", d, 32'h000ABCDE);
    endtask

    task automatic t_order();
        logic [31:0] d;
        byte_mode = 0; word_width_m1 = 5'd7;
        slave_sel = 3'd3;
        send_bits(32'h01, 8, 1'b0, 1'b0);
        end_unit(1'b0, 1'b0);
        pop(d);
        chk("R2 lsb slave reverses msb stream", d, 32'h80);
        lsb_first_cfg = 6'b111111; slave_sel = 3'd7;
        send_bits(32'h01, 8, 1'b0, 1'b0);
        end_unit(1'b0, 1'b0);
        pop(d);
        chk("R2 out-of-range slave is msb", d, 32'h01);
        lsb_first_cfg = 6'b001110;
    endtask

    task automatic t_gated_shift();
        logic [31:0] d;
        byte_mode = 0; word_width_m1 = 5'd15; slave_sel = 3'd0;
        send_bits(32'h1234, 16, 1'b0, 1'b1);
        end_unit(1'b0, 1'b0);
        pop(d);
        chk("R1 sdi ignored without shift_en", d, 32'h1234);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        byte_mode = 1; slave_sel = 3'd0;
        send_bits(32'h11, 8, 1'b0, 1'b0); end_unit(1'b0, 1'b0);
        send_bits(32'h22, 8, 1'b0, 1'b0); end_unit(1'b0, 1'b0);
        send_bits(32'h33, 8, 1'b0, 1'b0); end_unit(1'b0, 1'b0);
        chk("R4 no push before fourth byte", {31'd0, rd_ready}, 32'd0);
        send_bits(32'h44, 8, 1'b0, 1'b0); end_unit(1'b0, 1'b0);
        chk("R4 push after fourth byte", {31'd0, rd_ready}, 32'd1);
        pop(d);
        chk("R4 msb byte packing", d, 32'h44332211);
        slave_sel = 3'd1;
        send_bits(32'hA5, 8, 1'b1, 1'b0); end_unit(1'b0, 1'b0);
        send_bits(32'h3C, 8, 1'b1, 1'b0); end_unit(1'b0, 1'b0);
        send_bits(32'h0F, 8, 1'b1, 1'b0); end_unit(1'b0, 1'b0);
        send_bits(32'hF0, 8, 1'b1, 1'b0); end_unit(1'b0, 1'b0);
        pop(d);
        chk("R4 lsb byte packing", d, 32'hF00F3CA5);
        byte_mode = 0; slave_sel = 3'd0;
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        word_width_m1 = 5'd31; slave_sel = 3'd0;
        put_word(32'hAAAA0001);
        put_word(32'hBBBB0002);
        chk("R6 two words held, no error", {31'd0, rd_err}, 32'd0);
        put_word(32'hCCCC0003);
        chk("R9 third word sets rd_err", {31'd0, rd_err}, 32'd1);
        @(negedge clk);
        chk("R10 rd_err sticky", {31'd0, rd_err}, 32'd1);
        status_read();
        chk("R10 status read clears", {31'd0, rd_err}, 32'd0);
        pop(d);
        chk("R6 first word in order", d, 32'hAAAA0001);
        pop(d);
        chk("R9 second word kept", d, 32'hBBBB0002);
        chk("R8 empty after drain", {31'd0, rd_ready}, 32'd0);
        pop(d);
        chk("R7 empty read returns zero", d, 32'd0);
        chk("R7 empty read keeps ready low", {31'd0, rd_ready}, 32'd0);
    endtask

    task automatic t_pop_makes_room();
        logic [31:0] d;
        put_word(32'h11110001);
        put_word(32'h22220002);
        send_bits(32'h33330003, 32, 1'b0, 1'b0);
        end_unit(1'b1, 1'b0);
        chk("R9 same-cycle pop accepts word", {31'd0, rd_err}, 32'd0);
        chk("R9 popped head", rd_data, 32'h11110001);
        pop(d);
        chk("R9 next word", d, 32'h22220002);
        pop(d);
        chk("R9 accepted word", d, 32'h33330003);
    endtask

    task automatic t_stat_vs_ovf();
        logic [31:0] d;
        put_word(32'h0000AAAA);
        put_word(32'h0000BBBB);
        send_bits(32'h0000CCCC, 32, 1'b0, 1'b0);
        end_unit(1'b0, 1'b1);
        chk("R10 overrun beats status clear", {31'd0, rd_err}, 32'd1);
        status_read();
        chk("R10 later status clears", {31'd0, rd_err}, 32'd0);
        pop(d);
        chk("R9 head intact", d, 32'h0000AAAA);
        pop(d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_full();
        t_width20();
        t_order();
        t_gated_shift();
        t_bytes();
        t_overrun();
        t_pop_makes_room();
        t_stat_vs_ovf();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule